// File: doc/BRIEF.md
# Register File with Base-Bump Write Port

This block is a general-purpose register store for a processor datapath. It has two combinational read ports and two write ports that commit on the rising clock edge. The primary write port takes an explicit target index, a data word and an enable. The secondary write port has no index input: its target is always the register selected by read index A, and its data is made inside the block by adding a fixed step to that register's current value.

Together the two ports let a load-with-post-increment instruction finish in one cycle. The loaded word goes through the primary port to its destination, and the base register is advanced through the secondary port on the same edge. Instruction decode, memory access and the ALU sit outside the block. Every control arrives as a plain input.

Top module: `dual_wr_regfile`

## Requirements
- R1: The file holds NREGS (default 32) registers of XLEN (default 32) bits. Read port A returns entry `rd_a_idx` and read port B returns entry `rd_b_idx`, combinationally.
- R2: Entry 0 always reads as zero on both read ports.
- R3: When `wr_en` is 1 and `wr_idx` is nonzero, entry `wr_idx` takes `wr_data` at the rising edge. Reads in the cycle before that edge return the old value.
- R4: When `bump_en` is 1, the entry named by `rd_a_idx` takes its pre-edge value plus STEP (default 4), modulo 2^XLEN, at the rising edge. The port has no separate index input.
- R5: A write to entry 0 from either port has no effect.
- R6: When both ports target the same nonzero entry on one edge, the primary port's `wr_data` is stored.
- R7: When the two ports target different entries, both updates commit on the same edge.
- R8: With `rst` at 1, a rising edge clears every entry to zero. Reset is synchronous and active high, and it overrides both write ports.
- R9: An entry written by neither port keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high clear of all entries |
| rd_a_idx | input | 5 | Read index A; also the target of the bump port |
| rd_b_idx | input | 5 | Read index B |
| rd_a_data | output | 32 | Value of entry rd_a_idx |
| rd_b_data | output | 32 | Value of entry rd_b_idx |
| wr_en | input | 1 | Primary write enable |
| wr_idx | input | 5 | Primary write target |
| wr_data | input | 32 | Primary write data |
| bump_en | input | 1 | Enables the base-bump write of entry rd_a_idx |

## Verification
Every internal fault in this block ends in a stored value, so it shows up at the read ports one cycle after the faulty edge. A wrong bump target or step corrupts an entry that is read back on the next cycle. Broken write ordering on a collision leaves rd+4 where the loaded word should be. A zero entry that accepts a write returns a nonzero value from index 0 as soon as the edge has passed. To catch faults that are masked until later, the bench sweeps every index as target and as bump base, and it reads the whole file back after each phase.

// File: rtl/dual_wr_regfile_pkg.sv
package dual_wr_regfile_pkg;
  // Step added by the secondary (base-bump) write port
  localparam int unsigned BUMP_STEP = 4;

  // Sum used by the base-bump port; wraps at the word width
  function automatic logic [31:0] bump_value(input logic [31:0] base,
                                             input int unsigned step);
    bump_value = base + step;
  endfunction
endpackage

// File: rtl/rf_bump_unit.sv
module rf_bump_unit #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic [XLEN-1:0] base,
  output logic [XLEN-1:0] bumped
);
  localparam logic [XLEN-1:0] STEP_W = XLEN'(STEP);
  always_comb bumped = base + STEP_W;
endmodule

// File: rtl/rf_port_arbiter.sv
module rf_port_arbiter #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic [AW-1:0]   entry_idx,
  input  logic            p1_en,
  input  logic [AW-1:0]   p1_idx,
  input  logic [XLEN-1:0] p1_data,
  input  logic            p2_en,
  input  logic [AW-1:0]   p2_idx,
  input  logic [XLEN-1:0] p2_data,
  output logic            hit,
  output logic [XLEN-1:0] data
);
  logic p1_hit, p2_hit;
  always_comb begin
    p1_hit = p1_en && (p1_idx == entry_idx) && (entry_idx != '0);
    p2_hit = p2_en && (p2_idx == entry_idx) && (entry_idx != '0);
    hit    = p1_hit || p2_hit;
    data   = p1_hit ? p1_data : p2_data;
  end
endmodule

// File: rtl/dual_wr_regfile.sv
module dual_wr_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int STEP  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NREGS)-1:0] rd_a_idx,
  input  logic [$clog2(NREGS)-1:0] rd_b_idx,
  output logic [XLEN-1:0]          rd_a_data,
  output logic [XLEN-1:0]          rd_b_data,
  input  logic                     wr_en,
  input  logic [$clog2(NREGS)-1:0] wr_idx,
  input  logic [XLEN-1:0]          wr_data,
  input  logic                     bump_en
);
  localparam int AW = $clog2(NREGS);

  logic [XLEN-1:0] regs [NREGS];
  logic [XLEN-1:0] bump_data;
  logic [NREGS-1:0] entry_hit;
  logic            collide;

  // Combinational reads; entry 0 is never written so it reads zero
  always_comb begin
    rd_a_data = regs[rd_a_idx];
    rd_b_data = regs[rd_b_idx];
  end

  rf_bump_unit #(.XLEN(XLEN), .STEP(STEP)) u_bump (
    .base(rd_a_data), .bumped(bump_data)
  );

  assign collide = wr_en && bump_en && (wr_idx == rd_a_idx) && (wr_idx != '0);

  assign entry_hit[0] = 1'b0;
  always_ff @(posedge clk) regs[0] <= '0;

  for (genvar g = 1; g < NREGS; g++) begin : g_entry
    logic            hit;
    logic [XLEN-1:0] nxt;
    rf_port_arbiter #(.XLEN(XLEN), .AW(AW)) u_arb (
      .entry_idx(AW'(g)),
      .p1_en(wr_en), .p1_idx(wr_idx), .p1_data(wr_data),
      .p2_en(bump_en), .p2_idx(rd_a_idx), .p2_data(bump_data),
      .hit(hit), .data(nxt)
    );
    assign entry_hit[g] = hit;
    always_ff @(posedge clk) begin
      if (rst)      regs[g] <= '0;
      else if (hit) regs[g] <= nxt;
    end
  end

  // R2
  zero_reads_zero_chk: assert property (@(posedge clk)
    (rd_a_idx == '0) |-> (rd_a_data == '0));

  // R4
  bump_adds_step_chk: assert property (@(posedge clk) disable iff (rst)
    (bump_en && !wr_en && rd_a_idx != '0) |=>
      (regs[$past(rd_a_idx)] == $past(rd_a_data) + XLEN'(STEP)));

  // R6
  primary_wins_chk: assert property (@(posedge clk) disable iff (rst)
    collide |=> (regs[$past(wr_idx)] == $past(wr_data)));

  // R8
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (rd_b_data == '0));

  // R7
  at_most_two_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(entry_hit) <= 2);

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !bump_en && !rst) |=> $stable(rd_b_data) || $changed(rd_b_idx));
endmodule

// File: tb/dual_wr_regfile_bench.sv
module dual_wr_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 0;
  logic        rst;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, bump_en;

  int checks = 0, fails = 0;
  logic [31:0] model [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_wr_regfile u_dual_wr_regfile (
    .clk(clk), .rst(rst), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .bump_en(bump_en)
  );

  function automatic logic [31:0] pat(input int i, input int k);
    pat = 32'hA5000000 ^ (i * 32'h01010101) ^ (k << 8);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Commit one edge; update the model with the requirement-driven rules
  task automatic step(input logic we, input logic [4:0] wi, input logic [31:0] wd,
                      input logic be, input logic [4:0] ai);
    logic [31:0] base;
    wr_en = we; wr_idx = wi; wr_data = wd; bump_en = be; rd_a_idx = ai;
    #1;
    base = model[ai];
    @(posedge clk); #1;
    if (be && ai != 0) model[ai] = base + 32'd4;
    if (we && wi != 0) model[wi] = wd;
    wr_en = 0; bump_en = 0;
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < N; i++) begin
      rd_b_idx = 5'(i); #1;
      check(req, rd_b_data, model[i]);
    end
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = 0;
    rst = 1; wr_en = 0; bump_en = 0; wr_idx = 0; wr_data = 0; rd_a_idx = 0; rd_b_idx = 0;
    @(posedge clk); @(posedge clk); #1;
    rst = 0;
    sweep("R8 reset");

    // R3 and R5: primary write to every entry, with the old value visible before the edge
    for (int i = 0; i < N; i++) begin
      rd_b_idx = 5'(i);
      wr_en = 1; wr_idx = 5'(i); wr_data = pat(i, 1); #1;
      check("R3 pre-edge", rd_b_data, model[i]);
      step(1, 5'(i), pat(i, 1), 0, 0);
    end
    sweep("R3/R5 primary sweep");
    rd_a_idx = 0; #1; check("R2 port A zero", rd_a_data, 32'd0);

    // R4: bump each entry, including a wrap
    step(1, 5'd7, 32'hFFFFFFFE, 0, 0);
    for (int i = 0; i < N; i++) step(0, 0, 0, 1, 5'(i));
    sweep("R4 bump sweep");
    rd_a_idx = 5'd7; #1; check("R4 wrap", rd_a_data, 32'h00000002);

    // R7: load with increment to distinct entries
    for (int i = 1; i < N; i++) step(1, 5'((i + 5) % N), pat(i, 2), 1, 5'(i));
    sweep("R7 dual commit");

    // R6: collision
    for (int i = 0; i < N; i++) step(1, 5'(i), pat(i, 3), 1, 5'(i));
    sweep("R6 collision");

    // R9: idle cycles keep state
    step(0, 5'd3, 32'h12345678, 0, 5'd3);
    sweep("R9 hold");

    // R8: reset overrides writes
    rst = 1; wr_en = 1; wr_idx = 5'd9; wr_data = 32'hDEADBEEF; bump_en = 1; rd_a_idx = 5'd4;
    @(posedge clk); #1;
    rst = 0; wr_en = 0; bump_en = 0;
    for (int i = 0; i < N; i++) model[i] = 0;
    sweep("R8 reset override");
    rd_a_idx = 5'd9; #1; check("R1 port A after reset", rd_a_data, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule